// File: doc/BRIEF.md
# Hardware Event Router

This block connects event sources to event consumers inside a controller so that one peripheral can trigger another with no processor involvement. Sources are single-cycle pulses, such as a timer compare or overflow, an analog converter finishing a sample, or an edge on an external fault pin. Consumers include a converter start input, a memory-transfer request and a motor drive shutdown input. Each consumer owns one routing channel. The channel holds an enable bit and a field that names the source it listens to. Once software has written those registers, routing runs entirely in hardware.

Every routed pulse leaves as a single-cycle action strobe exactly three clock cycles after it arrives, with no jitter. This makes chains possible. A timer pulse can start a conversion, and the converter's done pulse can then raise a transfer request, with each hop costing a fixed three cycles. A per-channel sticky overrun flag records a strobe that is issued while the consumer reports itself busy. Software clears the flag by writing a one to it.

Each overrun flag is held by a two-state machine, and the routing itself is a plain three-register delay line. The two states are `OVR_IDLE` (no overrun recorded) and `OVR_HELD` (overrun recorded). The transition *record* goes from `OVR_IDLE` to `OVR_HELD` when a strobe leaves while busy is high. The transition *release* goes from `OVR_HELD` to `OVR_IDLE` on a clear write, provided no new overrun arrives in the same cycle. In every other case the state holds.

Top module: `evt_route_fabric`

## Requirements
- R1: After reset all strobes are 0, all overrun flags are 0, and every channel reads back as all zeros, which means disabled with select 0.
- R2: If channel c is enabled with select s, and source s pulses in cycle n, then `usr_strobe[c]` is high in cycle n+3 and is not raised by that pulse in any other cycle.
- R3: A channel never strobes while it is disabled. It also never strobes when its select value is GEN_N or larger.
- R4: Pulses on consecutive cycles give strobes on consecutive cycles, in the same order and in the same number. One source may drive several channels in the same cycle.
- R5: A write in cycle w affects only pulses from cycle w+1 onward. A pulse in cycle w or earlier finishes under the previous mapping.
- R6: `cfg_rdata` shows the channel addressed by `cfg_addr` in the same cycle. Bits [SELW-1:0] hold the select, bit SELW holds the enable, and bit SELW+1 holds the overrun flag.
- R7: A strobe on channel c in a cycle where `usr_busy[c]` is high sets `usr_overrun[c]` from the next cycle on. A channel whose busy input is low never sets its flag.
- R8: The overrun flag is sticky. A write to channel c with bit SELW+1 at 1 clears it, and a write with that bit at 0 leaves it set. When a new overrun and a clear arrive in the same cycle, the flag stays set.
- R9: Chains work with a fixed latency. A timer pulse starts a conversion 3 cycles later, and the conversion-done pulse raises a transfer request 3 cycles after it arrives. A fault-pin pulse reaches a drive-shutdown channel in 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_pulse | input | GEN_N | Single-cycle event pulses, one bit per source |
| usr_busy | input | USR_N | Busy indication from each consumer |
| cfg_we | input | 1 | Write strobe for channel configuration |
| cfg_addr | input | CHW | Channel index for read and write |
| cfg_wdata | input | SELW+2 | Write data: bits [SELW-1:0] are the select, bit SELW is the enable, bit SELW+1 is overrun-clear |
| cfg_rdata | output | SELW+2 | Addressed channel: select, enable and overrun flag |
| usr_strobe | output | USR_N | Single-cycle action strobe per consumer |
| usr_overrun | output | USR_N | Sticky overrun flag per consumer |

## Verification
The bench builds the block with GEN_N=6 and USR_N=4. With six sources the select field is 3 bits wide, so select values 6 and 7 exist and the out-of-range case in R3 can be reached. Four channels are enough to run a three-hop chain (timer, conversion, transfer) and a fault-to-shutdown path side by side. They also allow one source to fan out to two channels while a third, disabled channel listens to the same source.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;

    // Fixed source-to-strobe latency in clock cycles.
    localparam int LAT = 3;

    // State of one channel's overrun flag.
    typedef enum logic {
        OVR_IDLE = 1'b0,
        OVR_HELD = 1'b1
    } ovr_state_e;

endpackage

// File: rtl/evt_route_cfg.sv
module evt_route_cfg #(
    parameter int USR_N = 4,
    parameter int SELW  = 3,
    parameter int CHW   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [CHW-1:0]             cfg_addr,
    input  logic [SELW+1:0]            cfg_wdata,
    output logic [USR_N-1:0]           ch_en,
    output logic [USR_N-1:0][SELW-1:0] ch_sel,
    output logic [USR_N-1:0]           ch_clr
);
    localparam int EN_BIT  = SELW;
    localparam int CLR_BIT = SELW + 1;

    for (genvar c = 0; c < USR_N; c++) begin : g_chan
        logic wr_hit;
        assign wr_hit    = cfg_we && (cfg_addr == CHW'(c));
        assign ch_clr[c] = wr_hit && cfg_wdata[CLR_BIT];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_en[c]  <= 1'b0;
                ch_sel[c] <= '0;
            end else if (wr_hit) begin
                ch_en[c]  <= cfg_wdata[EN_BIT];
                ch_sel[c] <= cfg_wdata[SELW-1:0];
            end
        end
    end

endmodule

// File: rtl/evt_route_match.sv
module evt_route_match #(
    parameter int GEN_N = 8,
    parameter int USR_N = 4,
    parameter int SELW  = 3
) (
    input  logic [GEN_N-1:0]           gen_pulse,
    input  logic [USR_N-1:0]           ch_en,
    input  logic [USR_N-1:0][SELW-1:0] ch_sel,
    output logic [USR_N-1:0]           hit
);
    // Pad the source vector to the full select range. Select codes past
    // the last real source then pick a constant zero.
    localparam int PADN = 1 << SELW;

    logic [PADN-1:0] gen_pad;
    assign gen_pad = PADN'(gen_pulse);

    for (genvar c = 0; c < USR_N; c++) begin : g_hit
        assign hit[c] = ch_en[c] && gen_pad[ch_sel[c]];
    end

endmodule

// File: rtl/evt_route_pipe.sv
module evt_route_pipe #(
    parameter int W     = 4,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [DEPTH-1:0][W-1:0] stage;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[k] <= '0;
                else        stage[k] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[k] <= '0;
                else        stage[k] <= stage[k-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/evt_route_ovr.sv
module evt_route_ovr #(
    parameter int USR_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [USR_N-1:0] set,
    input  logic [USR_N-1:0] clr,
    output logic [USR_N-1:0] flag
);
    import evt_route_pkg::*;

    for (genvar c = 0; c < USR_N; c++) begin : g_fsm
        ovr_state_e state_q;
        ovr_state_e state_d;

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                OVR_IDLE: if (set[c])               state_d = OVR_HELD;
                OVR_HELD: if (clr[c] && !set[c])    state_d = OVR_IDLE;
                default:                            state_d = OVR_IDLE;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= OVR_IDLE;
            else        state_q <= state_d;
        end

        always_comb begin
            flag[c] = (state_q == OVR_HELD);
        end
    end

endmodule

// File: rtl/evt_route_fabric.sv
module evt_route_fabric #(
    parameter int GEN_N = 8,
    parameter int USR_N = 4,
    parameter int SELW  = (GEN_N > 1) ? $clog2(GEN_N) : 1,
    parameter int CHW   = (USR_N > 1) ? $clog2(USR_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GEN_N-1:0] gen_pulse,
    input  logic [USR_N-1:0] usr_busy,
    input  logic             cfg_we,
    input  logic [CHW-1:0]   cfg_addr,
    input  logic [SELW+1:0]  cfg_wdata,
    output logic [SELW+1:0]  cfg_rdata,
    output logic [USR_N-1:0] usr_strobe,
    output logic [USR_N-1:0] usr_overrun
);
    logic [USR_N-1:0]           ch_en;
    logic [USR_N-1:0][SELW-1:0] ch_sel;
    logic [USR_N-1:0]           ch_clr;
    logic [USR_N-1:0]           hit;
    logic [USR_N-1:0]           ovr_set;

    evt_route_cfg #(.USR_N(USR_N), .SELW(SELW), .CHW(CHW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .ch_en    (ch_en),
        .ch_sel   (ch_sel),
        .ch_clr   (ch_clr)
    );

    evt_route_match #(.GEN_N(GEN_N), .USR_N(USR_N), .SELW(SELW)) u_match (
        .gen_pulse(gen_pulse),
        .ch_en    (ch_en),
        .ch_sel   (ch_sel),
        .hit      (hit)
    );

    evt_route_pipe #(.W(USR_N), .DEPTH(evt_route_pkg::LAT)) u_pipe (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (hit),
        .dout (usr_strobe)
    );

    assign ovr_set = usr_strobe & usr_busy;

    evt_route_ovr #(.USR_N(USR_N)) u_ovr (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (ovr_set),
        .clr  (ch_clr),
        .flag (usr_overrun)
    );

    always_comb begin
        cfg_rdata = '0;
        for (int c = 0; c < USR_N; c++) begin
            if (cfg_addr == CHW'(c)) begin
                cfg_rdata = {usr_overrun[c], ch_en[c], ch_sel[c]};
            end
        end
    end

endmodule

// File: rtl/evt_route_chk.sv
module evt_route_chk #(
    parameter int GEN_N = 8,
    parameter int USR_N = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [GEN_N-1:0] gen_pulse,
    input logic [USR_N-1:0] usr_busy,
    input logic [USR_N-1:0] usr_strobe,
    input logic [USR_N-1:0] usr_overrun,
    input logic [USR_N-1:0] ch_en,
    input logic [USR_N-1:0] ch_clr
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (usr_strobe == '0 && usr_overrun == '0));

    // R2
    strobe_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_strobe != '0) |-> ($past(gen_pulse, 3) != '0));

    for (genvar c = 0; c < USR_N; c++) begin : g_chan
        // R3
        strobe_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            usr_strobe[c] |-> $past(ch_en[c], 3));

        // R7
        overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (usr_strobe[c] && usr_busy[c]) |=> usr_overrun[c]);

        // R8
        overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (usr_overrun[c] && !ch_clr[c]) |=> usr_overrun[c]);

        // R8
        overrun_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (usr_overrun[c] && ch_clr[c] && !(usr_strobe[c] && usr_busy[c]))
                |=> !usr_overrun[c]);
    end

endmodule

bind evt_route_fabric evt_route_chk #(.GEN_N(GEN_N), .USR_N(USR_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_pulse  (gen_pulse),
    .usr_busy   (usr_busy),
    .usr_strobe (usr_strobe),
    .usr_overrun(usr_overrun),
    .ch_en      (ch_en),
    .ch_clr     (ch_clr)
);

// File: tb/evt_route_fabric_tb.sv
module evt_route_fabric_tb;
    localparam int GEN_N = 6;
    localparam int USR_N = 4;
    localparam int SELW  = 3;
    localparam int CHW   = 2;
    localparam int CW    = SELW + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [GEN_N-1:0] drv_gen = '0;
    logic [GEN_N-1:0] adc_gen = '0;
    logic [GEN_N-1:0] gen_pulse;
    logic [USR_N-1:0] usr_busy = '0;
    logic             cfg_we = 1'b0;
    logic [CHW-1:0]   cfg_addr = '0;
    logic [CW-1:0]    cfg_wdata = '0;
    logic [CW-1:0]    cfg_rdata;
    logic [USR_N-1:0] usr_strobe;
    logic [USR_N-1:0] usr_overrun;

    assign gen_pulse = drv_gen | adc_gen;

    evt_route_fabric #(.GEN_N(GEN_N), .USR_N(USR_N)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .gen_pulse  (gen_pulse),
        .usr_busy   (usr_busy),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .usr_strobe (usr_strobe),
        .usr_overrun(usr_overrun)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    bit mon_on = 1'b0;
    bit adc_on = 1'b0;
    int adc_cnt = 0;

    // Shadow of the channel configuration, kept by the bench.
    bit            sh_en  [USR_N];
    int unsigned   sh_sel [USR_N];

    // Scoreboard: expected strobe mask and requirement label, keyed by cycle.
    logic [USR_N-1:0] pend [int];
    string            plab [int];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [USR_N-1:0] route(input logic [GEN_N-1:0] g);
        logic [USR_N-1:0] r = '0;
        for (int c = 0; c < USR_N; c++)
            if (sh_en[c] && sh_sel[c] < GEN_N && g[sh_sel[c]]) r[c] = 1'b1;
        return r;
    endfunction

    task automatic push_exp(input int at, input logic [USR_N-1:0] m, input string req);
        if (pend.exists(at)) pend[at] = pend[at] | m;
        else                 pend[at] = m;
        plab[at] = req;
    endtask

    // Monitor: compares every cycle's strobes against the scoreboard.
    always @(negedge clk) begin
        if (mon_on) begin
            logic [USR_N-1:0] e;
            string            l;
            e = pend.exists(cyc) ? pend[cyc] : '0;
            l = plab.exists(cyc) ? plab[cyc] : "R3";
            chk(l, int'(usr_strobe), int'(e));
            if (pend.exists(cyc)) pend.delete(cyc);
            if (plab.exists(cyc)) plab.delete(cyc);
        end
    end

    // Converter model for the chain test: done pulse on source 1,
    // two cycles after the start strobe on channel 0.
    always @(negedge clk) begin
        if (adc_cnt == 1) begin
            adc_gen = GEN_N'(2);
            push_exp(cyc + 3, route(GEN_N'(2)), "R9");
        end else begin
            adc_gen = '0;
        end
        if (adc_cnt > 0) adc_cnt--;
        if (adc_on && usr_strobe[0]) adc_cnt = 2;
    end

    // Driver: one cycle of stimulus; pushes the expected strobes.
    task automatic drive(input logic [GEN_N-1:0] g, input bit we, input int a,
                         input logic [CW-1:0] d, input string req);
        @(negedge clk);
        drv_gen   = g;
        cfg_we    = we;
        cfg_addr  = CHW'(a);
        cfg_wdata = d;
        if (g != '0) push_exp(cyc + 3, route(g), req);
        if (we) begin
            sh_en[a]  = d[SELW];
            sh_sel[a] = d[SELW-1:0];
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0, 1'b0, 0, '0, "");
    endtask

    task automatic cfg(input int a, input bit clr, input bit en, input int sel);
        drive('0, 1'b1, a, {clr, en, SELW'(sel)}, "");
    endtask

    task automatic peek(input int a, input logic [CW-1:0] exp, input string req);
        @(negedge clk);
        drv_gen  = '0;
        cfg_we   = 1'b0;
        cfg_addr = CHW'(a);
        #1;
        chk(req, int'(cfg_rdata), int'(exp));
    endtask

    initial begin
        for (int c = 0; c < USR_N; c++) begin sh_en[c] = 0; sh_sel[c] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: reset state
        chk("R1", int'(usr_strobe), 0);
        chk("R1", int'(usr_overrun), 0);
        for (int a = 0; a < USR_N; a++) peek(a, '0, "R1");

        // R2 / R4: fan-out of one source, disabled listener stays quiet (R3)
        cfg(0, 0, 1, 2);
        cfg(1, 0, 1, 5);
        cfg(2, 0, 0, 2);
        cfg(3, 0, 1, 2);
        drive(6'b000100, 0, 0, '0, "R2");
        idle(4);

        // R3: select beyond the last source never matches
        cfg(2, 0, 1, 7);
        drive(6'b111111, 0, 0, '0, "R3");
        idle(4);

        // R4: back-to-back pulses keep order and count
        drive(6'b000100, 0, 0, '0, "R4");
        drive(6'b000100, 0, 0, '0, "R4");
        drive(6'b100000, 0, 0, '0, "R4");
        drive(6'b100100, 0, 0, '0, "R4");
        idle(5);

        // R5: remap channel 0 while pulses are in flight
        drive(6'b000100, 0, 0, '0, "R5");
        drive(6'b000100, 1, 0, {1'b0, 1'b1, 3'd5}, "R5");
        drive(6'b000100, 0, 0, '0, "R5");
        drive(6'b100000, 0, 0, '0, "R5");
        idle(5);

        // R6: readback of select, enable and flag
        peek(0, 5'b01101, "R6");
        peek(2, 5'b01111, "R6");
        peek(3, 5'b01010, "R6");

        // R7: strobe while busy sets the flag; idle channel does not
        usr_busy = 4'b0010;
        drive(6'b100000, 0, 0, '0, "R7");
        idle(4);
        chk("R7", int'(usr_overrun), 4'b0010);
        peek(1, 5'b11101, "R6");

        // R8: sticky, write with clear bit 0 keeps it, clear bit 1 drops it
        idle(3);
        chk("R8", int'(usr_overrun[1]), 1);
        cfg(1, 0, 1, 5);
        idle(1);
        chk("R8", int'(usr_overrun[1]), 1);
        cfg(1, 1, 1, 5);
        idle(1);
        chk("R8", int'(usr_overrun[1]), 0);

        // R8: new overrun in the same cycle as a clear wins
        drive(6'b100000, 0, 0, '0, "R8");
        idle(2);
        cfg(1, 1, 1, 5);
        idle(2);
        chk("R8", int'(usr_overrun[1]), 1);
        usr_busy = '0;
        cfg(1, 1, 1, 5);
        idle(1);
        chk("R8", int'(usr_overrun), 0);

        // R9: timer -> conversion start -> transfer request, and fault -> shutdown
        cfg(0, 0, 1, 0);
        cfg(1, 0, 1, 1);
        cfg(2, 0, 1, 4);
        cfg(3, 0, 0, 0);
        idle(3);
        adc_on = 1'b1;
        drive(6'b000001, 0, 0, '0, "R9");
        idle(3);
        chk("R9", int'(usr_strobe[0]), 1);
        idle(5);
        chk("R9", int'(usr_strobe[1]), 1);
        idle(2);
        adc_on = 1'b0;
        drive(6'b010000, 0, 0, '0, "R9");
        idle(3);
        chk("R9", int'(usr_strobe[2]), 1);
        idle(6);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule